// File: doc/BRIEF.md
# Reference Switch Phase Step Absorber

This block sits between the selected timing reference and the phase detector of a digital loop. It does not pass the reference edge strobe straight through. It emits a virtual reference strobe, which is the reference edge delayed by a programmable number of master-clock ticks. The delay is held as a tick count modulo the reference period.

When the system moves to another reference, a capture strobe arms a measurement. The block waits for the next reference edge and counts ticks until the loop's feedback edge arrives. It then loads that count as the new delay. The new virtual reference therefore falls where the feedback, and so the old virtual reference, already sits, and the loop sees no phase step. The measured offset is absolute, so the offsets of successive switches build up in the delay. The capture is honoured only while the enable input is high. Otherwise the delay, and with it the input-to-output phase relation, stays unchanged.

An active-low clear brings the delay back to zero. The clear is first synchronised and must stay low for a minimum number of clocks. The delay is then unwound in bounded steps, one step per 8 kHz frame tick, along the shorter way round the period. The control state machine has four states:

- **IDLE**: holds the delay.
- **WAIT_REF**: entered on an enabled capture strobe; waits for the new reference edge.
- **MEASURE**: entered on a reference edge without feedback; counts until the feedback edge, then returns to IDLE and loads the count.
- **UNWIND**: entered from any state on a qualified clear; steps the delay on frame ticks and returns to IDLE once the delay is zero.

WAIT_REF also returns to IDLE directly, with a zero delay, when the feedback and the reference edges coincide.

Top module: `pstep_absorber`

## Requirements
- R1: After reset the delay is zero and no virtual reference strobe appears before the first reference strobe.
- R2: For a delay D, each reference strobe yields exactly one virtual reference strobe, D+1 clocks after it.
- R3: A capture strobe with the enable high makes the block measure the next reference strobe. If the feedback strobe comes k clocks after it, the delay becomes k. A feedback strobe in the same clock gives zero.
- R4: The measured count wraps modulo the period, so a feedback strobe PERIOD+j clocks after the reference strobe gives a delay of j.
- R5: A capture strobe with the enable low is ignored and the delay is unchanged.
- R6: The clear counts only after synchronisation and only when it has been seen low for CLR_MIN consecutive clocks. Shorter low pulses leave the delay unchanged.
- R7: While unwinding, each frame tick moves the delay toward zero by at most SLEW_TICKS. It moves downward when D is at most PERIOD/2 and upward, wrapping through PERIOD to zero, otherwise.
- R8: The final step lands exactly on zero. Unwinding then ends, and further frame ticks have no effect.
- R9: Capture strobes during unwinding are ignored.
- R10: Frame ticks outside unwinding leave the delay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_stb | input | 1 | One-clock strobe at each selected reference edge |
| fb_stb | input | 1 | One-clock strobe at each loop feedback edge |
| tie_en | input | 1 | Enables phase capture on a switch |
| sw_cap | input | 1 | One-clock strobe announcing a reference switch |
| clr_n | input | 1 | Active-low asynchronous clear request for the delay |
| frame_tick | input | 1 | 8 kHz frame strobe that paces the unwinding |
| vref_stb | output | 1 | Virtual reference strobe toward the phase detector |

## Verification
The bench builds the block with PERIOD=40, SLEW_TICKS=3 and CLR_MIN=4. With these values every delay, including the largest value of 39, shows up within one reference interval. The wrap of the measured count also comes within reach, since it needs only a feedback strobe 43 clocks after the reference strobe. With a slew of 3 on a 40-tick period, the downward path, the upward path with its wrap to zero, the tie at the half period and the clipped final step each complete in a handful of frame ticks. A clear qualification of four clocks lets a two-clock pulse stand as the case that must be rejected.

// File: rtl/pstep_pkg.sv
package pstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_REF = 2'd1,
        ST_MEASURE  = 2'd2,
        ST_UNWIND   = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/pstep_clr_qual.sv
module pstep_clr_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int CLR_MIN     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic clr_hit
);
    localparam int CW = $clog2(CLR_MIN + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(CLR_MIN);
    localparam logic [CW-1:0] CNT_FIRE = CW'(CLR_MIN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt;
    logic                   low_seen;

    assign low_seen = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], clr_n};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!low_seen) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_TOP) begin
            low_cnt <= low_cnt + CW'(1);
        end
    end

    assign clr_hit = low_seen && (low_cnt == CNT_FIRE);

    // R6
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !clr_hit);

    generate
        if (CLR_MIN > 1) begin : g_min_chk
            // R6
            clr_not_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(low_seen) |-> !clr_hit);
        end
    endgenerate
endmodule

// File: rtl/pstep_delay_line.sv
module pstep_delay_line #(
    parameter int PERIOD = 2500,
    parameter int DW     = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic [DW-1:0] delay,
    output logic          vref_stb
);
    localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);
    localparam logic [DW-1:0] ONE  = DW'(1);

    logic [DW-1:0] ph_q;
    logic [DW-1:0] count_now;
    logic          fired_q;
    logic          hit;

    always_comb begin
        if (ref_stb) begin
            count_now = '0;
        end else if (ph_q == LAST) begin
            count_now = ph_q;
        end else begin
            count_now = ph_q + ONE;
        end
        hit = (count_now == delay) && (ref_stb || !fired_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= LAST;
            fired_q  <= 1'b1;
            vref_stb <= 1'b0;
        end else begin
            ph_q     <= count_now;
            fired_q  <= ref_stb ? hit : (fired_q | hit);
            vref_stb <= hit;
        end
    end

    // R2
    once_per_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vref_stb && !ref_stb) |=> !vref_stb);

    // R2
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && delay == '0) |=> vref_stb);
endmodule

// File: rtl/pstep_ctl.sv
module pstep_ctl
    import pstep_pkg::*;
#(
    parameter int PERIOD     = 2500,
    parameter int DW         = 12,
    parameter int SLEW_TICKS = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic          fb_stb,
    input  logic          tie_en,
    input  logic          sw_cap,
    input  logic          frame_tick,
    input  logic          clr_hit,
    output logic [DW-1:0] delay
);
    localparam logic [DW-1:0] LAST   = DW'(PERIOD - 1);
    localparam logic [DW-1:0] HALF   = DW'(PERIOD / 2);
    localparam logic [DW-1:0] SLEW_W = DW'(SLEW_TICKS);
    localparam logic [DW:0]   PER_W  = (DW+1)'(PERIOD);
    localparam logic [DW-1:0] ONE    = DW'(1);

    ctl_state_t    st_q, st_nxt;
    logic [DW-1:0] meas_q;
    logic [DW-1:0] meas_inc;
    logic [DW-1:0] step_val;
    logic [DW:0]   up_gap;

    always_comb begin
        meas_inc = (meas_q == LAST) ? '0 : meas_q + ONE;
        up_gap   = PER_W - {1'b0, delay};
        if (delay <= HALF) begin
            step_val = (delay <= SLEW_W) ? '0 : delay - SLEW_W;
        end else begin
            step_val = (up_gap <= {1'b0, SLEW_W}) ? '0 : delay + SLEW_W;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (clr_hit)                st_nxt = ST_UNWIND;
                else if (sw_cap && tie_en)  st_nxt = ST_WAIT_REF;
            end
            ST_WAIT_REF: begin
                if (clr_hit)                st_nxt = ST_UNWIND;
                else if (ref_stb && fb_stb) st_nxt = ST_IDLE;
                else if (ref_stb)           st_nxt = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (clr_hit)                st_nxt = ST_UNWIND;
                else if (fb_stb)            st_nxt = ST_IDLE;
            end
            ST_UNWIND: begin
                if (delay == '0)            st_nxt = ST_IDLE;
            end
            default:                        st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay  <= '0;
            meas_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    meas_q <= '0;
                end
                ST_WAIT_REF: begin
                    if (!clr_hit && ref_stb) begin
                        if (fb_stb) delay  <= '0;
                        else        meas_q <= ONE;
                    end
                end
                ST_MEASURE: begin
                    if (!clr_hit) begin
                        if (fb_stb) delay  <= meas_q;
                        else        meas_q <= meas_inc;
                    end
                end
                ST_UNWIND: begin
                    if (frame_tick && delay != '0) delay <= step_val;
                end
                default: begin
                    meas_q <= '0;
                end
            endcase
        end
    end

    // R7
    slew_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNWIND && frame_tick && delay != '0 && delay <= HALF)
        |=> (delay < $past(delay)) && (($past(delay) - delay) <= SLEW_W));

    // R7
    slew_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNWIND && frame_tick && delay > HALF)
        |=> (delay == '0) || ((delay > $past(delay)) && ((delay - $past(delay)) <= SLEW_W)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !clr_hit) |=> $stable(delay));

    // R8
    unwind_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNWIND && delay == '0) |=> (st_q == ST_IDLE));

    // R9
    unwind_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNWIND) |=> (st_q == ST_UNWIND || st_q == ST_IDLE));
endmodule

// File: rtl/pstep_absorber.sv
module pstep_absorber #(
    parameter int PERIOD      = 2500,
    parameter int SLEW_TICKS  = 1,
    parameter int CLR_MIN     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic fb_stb,
    input  logic tie_en,
    input  logic sw_cap,
    input  logic clr_n,
    input  logic frame_tick,
    output logic vref_stb
);
    localparam int DW = $clog2(PERIOD);

    logic          clr_hit;
    logic [DW-1:0] delay;

    pstep_clr_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .CLR_MIN     (CLR_MIN)
    ) u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .clr_hit (clr_hit)
    );

    pstep_ctl #(
        .PERIOD     (PERIOD),
        .DW         (DW),
        .SLEW_TICKS (SLEW_TICKS)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_stb    (ref_stb),
        .fb_stb     (fb_stb),
        .tie_en     (tie_en),
        .sw_cap     (sw_cap),
        .frame_tick (frame_tick),
        .clr_hit    (clr_hit),
        .delay      (delay)
    );

    pstep_delay_line #(
        .PERIOD (PERIOD),
        .DW     (DW)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_stb  (ref_stb),
        .delay    (delay),
        .vref_stb (vref_stb)
    );
endmodule

// File: tb/sim_pstep_absorber.sv
`timescale 1ns/1ps
module sim_pstep_absorber;
    localparam int PERIOD  = 40;
    localparam int SLEW    = 3;
    localparam int CLR_MIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0, fb_stb = 1'b0, tie_en = 1'b0, sw_cap = 1'b0;
    logic clr_n = 1'b1, frame_tick = 1'b0;
    logic vref_stb;

    int cyc = 0;
    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    int exp_q[$];
    string cur_req = "R1";

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    pstep_absorber #(
        .PERIOD(PERIOD), .SLEW_TICKS(SLEW), .CLR_MIN(CLR_MIN), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .tie_en(tie_en), .sw_cap(sw_cap), .clr_n(clr_n),
        .frame_tick(frame_tick), .vref_stb(vref_stb)
    );

    // monitor: pops expected strobe cycles and compares
    always @(negedge clk) begin
        if (rst_n && chk_on && vref_stb) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_errors++;
                $display("FAIL %s: unexpected vref at cycle %0d (expected none)", cur_req, cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    mon_errors++;
                    $display("FAIL %s: vref at cycle %0d, expected %0d", cur_req, cyc, e);
                end
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    endtask

    // driver: one reference strobe with an expected delay
    task automatic send_ref(input int d, input string req);
        cur_req = req;
        ref_stb = 1'b1;
        exp_q.push_back(cyc + 1 + d);
        @(negedge clk);
        ref_stb = 1'b0;
        repeat (PERIOD) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: vref missing, actual none, expected delay %0d", req, d);
            exp_q.delete();
        end
    endtask

    task automatic capture(input bit en, input int k);
        chk_on = 1'b0;
        tie_en = en;
        sw_cap = 1'b1;
        @(negedge clk);
        sw_cap = 1'b0;
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        repeat (k - 1) @(negedge clk);
        fb_stb = 1'b1;
        @(negedge clk);
        fb_stb = 1'b0;
        repeat (PERIOD + 2) @(negedge clk);
        tie_en = 1'b1;
        chk_on = 1'b1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic clear(input int n);
        clr_n = 1'b0;
        repeat (n) @(negedge clk);
        clr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout, expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (vref_stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: vref=%b expected 0", vref_stb);
        end
        chk_on = 1'b1;
        cur_req = "R1";
        repeat (2 * PERIOD) @(negedge clk);
        // R1 / R2: zero delay
        send_ref(0, "R1");
        send_ref(0, "R2");
        // R3: capture offset 10
        capture(1'b1, 10);
        send_ref(10, "R3");
        send_ref(10, "R2");
        // R5: disabled capture ignored
        capture(1'b0, 25);
        send_ref(10, "R5");
        // R4: count wraps modulo period
        capture(1'b1, PERIOD + 3);
        send_ref(3, "R4");
        // R3: maximum offset
        capture(1'b1, PERIOD - 1);
        send_ref(PERIOD - 1, "R3");
        // R10: frame ticks outside unwinding
        capture(1'b1, 10);
        tick(3);
        send_ref(10, "R10");
        // R6: short clear ignored
        clear(2);
        tick(2);
        send_ref(10, "R6");
        // R6 / R7: qualified clear, downward steps
        clear(CLR_MIN + 2);
        tick(1);
        send_ref(7, "R7");
        // R9: capture during unwinding ignored
        capture(1'b1, 30);
        send_ref(7, "R9");
        tick(2);
        send_ref(1, "R7");
        tick(1);
        send_ref(0, "R8");
        tick(2);
        send_ref(0, "R8");
        // R7: upward path with wrap to zero
        capture(1'b1, 33);
        clear(CLR_MIN + 2);
        tick(1);
        send_ref(36, "R7");
        tick(1);
        send_ref(39, "R7");
        tick(1);
        send_ref(0, "R8");
        // R7: tie at half period goes downward
        capture(1'b1, PERIOD / 2);
        clear(CLR_MIN + 2);
        tick(1);
        send_ref(17, "R7");
        tick(6);
        send_ref(0, "R8");
        // R3: capture works again after unwinding
        capture(1'b1, 5);
        send_ref(5, "R3");
        done = 1'b1;
        report();
        $finish;
    end
endmodule